// File: doc/BRIEF.md
# Scan-Ready Accumulator Datapath with Test-Mode Rule Repairs

This block is a small sequential datapath whose every flip-flop is a multiplexed-D scan cell, with all cells linked into one serial chain. The function is simple: an accumulator that adds a data word when enabled, a counter stepped by an internally divided tick and cleared by an internally generated clear, and a shared bus with three drivers, resolved by a multiplexer and backed by a keeper register.

The chain carries the usual scan rule repairs. A test-mode pin and the shift-enable pin together force the accumulator's enable on. The test-mode pin bypasses the divided tick so the counter steps on every clock, and it masks the internal clear. While shifting, the bus is handed to one fixed driver so that drivers never fight. A tester loads a pattern through the chain, applies the data inputs, gives one capture clock with shift disabled, and then shifts the response out while the next pattern shifts in.

Top module: `scan_rule_top`

## Requirements
- R1: With `rst` high at a rising edge (synchronous), every cell becomes 0, so `acc_out`, `cnt_out` and `scan_out` read 0.
- R2: With `se` high (and `tm` high), at each rising edge cell 0 takes `scan_in`, cell i takes cell i-1, and `scan_out` shows the last cell. Cell mapping: cells 0..3 are the accumulator (LSB first), cells 4..7 the counter, cells 8..11 the keeper, cell 12 the divider bit.
- R3: With `se` low, the accumulator becomes acc+`din` (mod 16) at the edge when `din_en` is 1 or `tm` is 1, and holds otherwise.
- R4: With `se` low, the divider bit inverts on every edge. With `tm` low the counter increments only on edges where the divider bit was 1; with `tm` high it increments on every edge.
- R5: With `tm` low and `se` low, if the accumulator equals 15 before an edge, the counter is 0 after it, overriding the increment. With `tm` high this clear never acts.
- R6: The bus drivers are 0 = accumulator, 1 = counter, 2 = `din`, enabled by `bus_en[0..2]`. `bus_out` is the bitwise OR of the enabled drivers' values, or the keeper value when no driver is enabled.
- R7: With `se` low, the keeper loads the current `bus_out` value at every edge.
- R8: With `se` high, only driver 0 is enabled whatever `bus_en` holds, so `bus_out` equals `acc_out`.
- R9: Exactly 13 shift clocks fully load a pattern. Unloading a response overlaps loading the next pattern, and `scan_out` presents the response's last cell first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tm | input | 1 | Test mode: forces enables, bypasses the tick, masks the internal clear |
| se | input | 1 | Shift enable: cells take their chain predecessor |
| scan_in | input | 1 | Serial chain input to cell 0 |
| din | input | 4 | Data word added to the accumulator; bus driver 2 |
| din_en | input | 1 | Functional accumulator enable |
| bus_en | input | 3 | Functional bus driver enables |
| scan_out | output | 1 | Serial chain output from the last cell |
| acc_out | output | 4 | Accumulator value |
| cnt_out | output | 4 | Counter value |
| bus_out | output | 4 | Resolved shared bus value |

## Verification
The assertions assume that `se` is raised only while `tm` is high. The counter's shift path depends on the tick bypass that only `tm` provides, so shifting with `tm` low is outside the block's use. The bench keeps `tm` high for every shift and capture, and returns both pins low for functional runs. In functional runs it deliberately drives several bus enables together and none at all. It also steers the accumulator to 15 so that the internal clear fires in functional mode and is seen to be masked during capture.

// File: rtl/scanfix_pkg.sv
package scanfix_pkg;

    localparam int DATA_W = 4;
    localparam int NDRV   = 3;

    // Chain order follows the packed layout: acc holds cells 0..DATA_W-1.
    typedef struct packed {
        logic              tog;
        logic [DATA_W-1:0] keep;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] acc;
    } state_t;

    localparam int CELLS = $bits(state_t);

    // Driver order: 0 accumulator, 1 counter, 2 data word.
    function automatic logic [DATA_W-1:0] bus_resolve(
        input logic [NDRV-1:0]   en,
        input logic [DATA_W-1:0] v_acc,
        input logic [DATA_W-1:0] v_cnt,
        input logic [DATA_W-1:0] v_din,
        input logic [DATA_W-1:0] v_keep
    );
        logic [DATA_W-1:0] drv [NDRV];
        logic [DATA_W-1:0] res;
        drv[0] = v_acc;
        drv[1] = v_cnt;
        drv[2] = v_din;
        res = '0;
        for (int k = 0; k < NDRV; k++) begin
            if (en[k]) res = res | drv[k];
        end
        if (en == '0) res = v_keep;
        return res;
    endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic se,
    input  logic en,
    input  logic clr,
    input  logic d,
    input  logic si,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (en)  q <= se ? si : d;
    end

    // R2: an enabled shifting cell takes its scan input
    a_r2_cell_shift: assert property (@(posedge clk) disable iff (rst)
        (se && en && !clr) |=> (q == $past(si)));

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         se,
    input  logic         scan_in,
    input  logic [N-1:0] d,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q,
    output logic         scan_out
);

    logic [N-1:0] si_vec;
    assign si_vec   = {q[N-2:0], scan_in};
    assign scan_out = q[N-1];

    for (genvar i = 0; i < N; i++) begin : g_cell
        scan_cell u_cell (
            .clk (clk),
            .rst (rst),
            .se  (se),
            .en  (en[i]),
            .clr (clr[i]),
            .d   (d[i]),
            .si  (si_vec[i]),
            .q   (q[i])
        );
    end

endmodule

// File: rtl/rule_fix_logic.sv
module rule_fix_logic
    import scanfix_pkg::*;
(
    input  logic                tm,
    input  logic                se,
    input  logic                din_en,
    input  logic [DATA_W-1:0]   din,
    input  logic [NDRV-1:0]     bus_en,
    input  state_t              cur,
    output state_t              nxt,
    output state_t              en_s,
    output state_t              clr_s,
    output logic [DATA_W-1:0]   bus_val
);

    logic            acc_en;
    logic            tick;
    logic            clr_int;
    logic            clr_cnt;
    logic [NDRV-1:0] drv_en;

    // Gated-register repair: enable forced by test mode or shift.
    assign acc_en  = din_en | tm | se;
    // Derived-tick bypass: test mode steps the counter every clock.
    assign tick    = cur.tog | tm;
    // Internal clear, held inactive for the whole of test mode.
    assign clr_int = (cur.acc == '1);
    assign clr_cnt = clr_int & ~tm;
    // Bus arbitration: shift hands the bus to driver 0 alone.
    assign drv_en  = se ? NDRV'(1) : bus_en;

    assign bus_val = bus_resolve(drv_en, cur.acc, cur.cnt, din, cur.keep);

    always_comb begin
        nxt.acc  = cur.acc + din;
        nxt.cnt  = cur.cnt + DATA_W'(1);
        nxt.keep = bus_val;
        nxt.tog  = ~cur.tog;

        en_s.acc  = {DATA_W{acc_en}};
        en_s.cnt  = {DATA_W{tick}};
        en_s.keep = '1;
        en_s.tog  = 1'b1;

        clr_s.acc  = '0;
        clr_s.cnt  = {DATA_W{clr_cnt}};
        clr_s.keep = '0;
        clr_s.tog  = 1'b0;
    end

endmodule

// File: rtl/scan_rule_top.sv
module scan_rule_top
    import scanfix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tm,
    input  logic              se,
    input  logic              scan_in,
    input  logic [DATA_W-1:0] din,
    input  logic              din_en,
    input  logic [NDRV-1:0]   bus_en,
    output logic              scan_out,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] cnt_out,
    output logic [DATA_W-1:0] bus_out
);

    state_t            st;
    state_t            nxt;
    state_t            en_s;
    state_t            clr_s;
    logic [CELLS-1:0]  q;

    assign st = state_t'(q);

    rule_fix_logic u_fix (
        .tm      (tm),
        .se      (se),
        .din_en  (din_en),
        .din     (din),
        .bus_en  (bus_en),
        .cur     (st),
        .nxt     (nxt),
        .en_s    (en_s),
        .clr_s   (clr_s),
        .bus_val (bus_out)
    );

    scan_chain #(.N(CELLS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .se       (se),
        .scan_in  (scan_in),
        .d        (nxt),
        .en       (en_s),
        .clr      (clr_s),
        .q        (q),
        .scan_out (scan_out)
    );

    assign acc_out = st.acc;
    assign cnt_out = st.cnt;

    // R2: shifting is only legal under test mode
    a_r2_shift_in_test: assert property (@(posedge clk) disable iff (rst)
        se |-> tm);

    // R3: capture under test mode always accumulates
    a_r3_forced_enable: assert property (@(posedge clk) disable iff (rst)
        (tm && !se) |=> (acc_out == DATA_W'($past(acc_out) + $past(din))));

    // R4: capture under test mode steps the counter regardless of divider
    a_r4_tick_bypass: assert property (@(posedge clk) disable iff (rst)
        (tm && !se) |=> (cnt_out == DATA_W'($past(cnt_out) + 1)));

    // R5: functional internal clear empties the counter
    a_r5_internal_clear: assert property (@(posedge clk) disable iff (rst)
        (!tm && !se && acc_out == '1) |=> (cnt_out == '0));

    // R8: while shifting the bus shows the accumulator driver only
    a_r8_shift_bus_owner: assert property (@(posedge clk) disable iff (rst)
        se |-> (bus_out == acc_out));

endmodule

// File: tb/tb_scan_rule_top.sv
`timescale 1ns/1ps
module tb_scan_rule_top;

    localparam int W = 4;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tm = 1'b0, se = 1'b0, scan_in = 1'b0, din_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [2:0]   bus_en = '0;
    logic         scan_out;
    logic [W-1:0] acc_out, cnt_out, bus_out;

    always #4 clk = ~clk;

    scan_rule_top dut (
        .clk(clk), .rst(rst), .tm(tm), .se(se), .scan_in(scan_in),
        .din(din), .din_en(din_en), .bus_en(bus_en),
        .scan_out(scan_out), .acc_out(acc_out), .cnt_out(cnt_out), .bus_out(bus_out)
    );

    typedef struct {
        logic         so;
        logic [W-1:0] acc;
        logic [W-1:0] cnt;
        logic [W-1:0] bus;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference state
    logic [W-1:0] m_acc = '0, m_cnt = '0, m_keep = '0;
    logic         m_tog = 1'b0;

    function automatic logic [W-1:0] ref_bus(logic [2:0] e, logic [W-1:0] a,
                                             logic [W-1:0] c, logic [W-1:0] d,
                                             logic [W-1:0] k);
        logic [W-1:0] r;
        r = '0;
        if (e[0]) r |= a;
        if (e[1]) r |= c;
        if (e[2]) r |= d;
        return (e == 3'b000) ? k : r;
    endfunction

    task automatic step(input logic r, input logic t, input logic s, input logic si,
                        input logic [W-1:0] dv, input logic de, input logic [2:0] be,
                        input string tag);
        logic [2:0]   ee;
        logic [W-1:0] bpre;
        logic [N-1:0] v;
        exp_t         e;
        @(negedge clk);
        rst = r; tm = t; se = s; scan_in = si; din = dv; din_en = de; bus_en = be;
        ee   = s ? 3'b001 : be;
        bpre = ref_bus(ee, m_acc, m_cnt, dv, m_keep);
        if (r) begin
            m_acc = '0; m_cnt = '0; m_keep = '0; m_tog = 1'b0;
        end else if (s) begin
            v = {m_tog, m_keep, m_cnt, m_acc};
            v = {v[N-2:0], si};
            {m_tog, m_keep, m_cnt, m_acc} = v;
        end else begin
            if (m_acc == 4'hF && !t)  m_cnt = '0;
            else if (m_tog || t)      m_cnt = m_cnt + 1'b1;
            if (de || t)              m_acc = m_acc + dv;
            m_keep = bpre;
            m_tog  = ~m_tog;
        end
        e.so  = m_tog;
        e.acc = m_acc;
        e.cnt = m_cnt;
        e.bus = ref_bus(ee, m_acc, m_cnt, dv, m_keep);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare shortly after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_cmp++;
                if (scan_out !== e.so || acc_out !== e.acc ||
                    cnt_out !== e.cnt || bus_out !== e.bus) begin
                    n_bad++;
                    $display("FAIL %s: so/acc/cnt/bus got %0b/%h/%h/%h exp %0b/%h/%h/%h",
                             e.tag, scan_out, acc_out, cnt_out, bus_out,
                             e.so, e.acc, e.cnt, e.bus);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]   lfsr;
        logic [N-1:0] pat1, pat2;
        lfsr = 8'hA5;
        // R1 reset state
        step(1, 0, 0, 0, 4'h0, 0, 3'b000, "R1 reset");
        step(1, 0, 0, 0, 4'h0, 0, 3'b000, "R1 reset");
        // R4 divided tick, R7 keeper with no driver
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 4'h3, 0, 3'b000, "R4 R7 idle tick");
        // R5 functional clear: reach acc 15 then watch counter empty
        step(0, 0, 0, 0, 4'hF, 1, 3'b010, "R3 R6 load 15");
        step(0, 0, 0, 0, 4'h0, 0, 3'b001, "R5 clear fires");
        step(0, 0, 0, 0, 4'h0, 0, 3'b000, "R5 R7 after clear");
        // R3 R6 R7 mixed functional patterns incl. contention
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(0, 0, 0, 0, lfsr[3:0], lfsr[4], lfsr[7:5], "R3 R4 R5 R6 R7 functional");
        end
        // R2 R8 R9 load pattern: tog 0, keep A, cnt 5, acc F
        pat1 = 13'h0A5F;
        for (int k = N - 1; k >= 0; k--)
            step(0, 1, 1, pat1[k], 4'h9, 0, 3'b110, "R2 R8 R9 shift load");
        // R3 R4 R5 capture: acc forced, counter steps, clear masked
        step(0, 1, 0, 0, 4'h2, 0, 3'b100, "R3 R4 R5 capture");
        // R9 unload overlapped with next load
        pat2 = 13'h1C3B;
        for (int k = N - 1; k >= 0; k--)
            step(0, 1, 1, pat2[k], 4'h6, 1, 3'b011, "R2 R8 R9 unload overlap");
        step(0, 1, 0, 0, 4'h7, 0, 3'b000, "R3 R4 capture 2");
        for (int k = 0; k < N; k++)
            step(0, 1, 1, 1'b0, 4'h0, 0, 3'b000, "R9 final unload");
        // back to functional use
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 4'h5, 1, 3'(i), "R3 R6 R7 resume");
        step(1, 0, 0, 0, 4'h0, 0, 3'b000, "R1 reset again");
        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule